// File: doc/BRIEF.md
# PWM Output Anti-Pop Ramp Sequencer

This block controls the duty word of a two-channel PWM headphone output stage during power transitions. A series DC-blocking capacitor sits between the output and the load. If the output jumped straight from ground to mid-rail, or back, the capacitor would pass that step to the load as an audible click. The sequencer avoids this. It holds the duty at zero while the stage is powered down. When power-down is released, it waits a fixed settling delay. It then raises the duty one LSB at a time to the half-scale bias point and only then enables audio. On a new power-down request it disables audio first and lowers the duty back to zero along the same slope.

The ramp slope comes from a 2-bit speed field. The four settings have step intervals in the proportion 2:4:6:13, which gives full ramps of roughly 0.1 s, 0.2 s, 0.3 s and 0.65 s for a suitable tick rate. Separate bypass inputs turn either ramp into a single-edge jump. A float input lets the output stage release its pins to high impedance while the block is idle and powered down.

The duty word feeds a PWM carrier generator outside this block. There is no data stream here: every pin is a plain level signal, sampled on each rising clock edge.

Top module: `pwm_pop_sequencer`

## Requirements
- R1: While rst_n is low, duty is 0 and audio_en is 0. The block is in its idle, powered-down phase, so out_float equals float_en.
- R2: While pwr_down is 1 in the idle phase, duty stays 0. After pwr_down goes to 0, the duty is held at 0 for a wait phase that ends on the WAIT_TICKS-th tick after the wait phase starts. If pwr_down returns to 1 during the wait phase, the block goes back to idle and no ramp occurs.
- R3: During a ramp, duty changes by exactly one LSB per step. A tick occurs once every TICK_DIV clocks, counted from reset release. A step occurs on every (M × STEP_UNIT)-th tick, where M is 2, 4, 6 or 13 for ramp_speed 00, 01, 10 or 11. ramp_speed is read live during the ramp. The tick count restarts at the first clock of each phase, and a tick that falls in that first clock is not counted.
- R4: Duty never exceeds HALF = 2^(DUTY_W-1). When a ramp-up reaches HALF, audio_en goes to 1 on that same edge, and duty holds at HALF for as long as audio_en is 1. audio_en is never 1 at any other duty.
- R5: When pwr_down is 1 during playback, audio_en falls on the next edge and duty stays at HALF on that edge. After that, duty ramps down at the R3 rate until it reaches 0, and the block becomes idle on the edge where duty reaches 0.
- R6: When byp_up is 1 at the end of the wait phase, duty jumps from 0 to HALF in one edge and audio_en rises on that same edge.
- R7: When byp_down is 1 and pwr_down is 1 during playback or a ramp-up, duty drops to 0 and the block becomes idle in one edge.
- R8: out_float is 1 only while float_en is 1 and the block is idle (powered down, duty 0). In every other phase it is 0.
- R9: When pwr_down is 1 during a ramp-up, the ramp reverses from the current duty without a jump. If the duty is still 0 at that point, the block returns directly to idle.
- R10: Once a ramp-down has started, clearing pwr_down does not stop it. Duty continues down to 0, and only after the block is idle does a new power-up sequence begin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_down | input | 1 | 1 requests the powered-down state; 0 allows power-up |
| ramp_speed | input | 2 | Ramp slope select (00 fastest, 11 slowest) |
| byp_up | input | 1 | 1 replaces the ramp-up with a single jump to HALF |
| byp_down | input | 1 | 1 replaces the ramp-down with a single drop to 0 |
| float_en | input | 1 | 1 allows the output pins to float while idle and powered down |
| duty | output | DUTY_W | Duty word for the PWM generator (HALF means 50 %) |
| audio_en | output | 1 | 1 while audio may drive the output |
| out_float | output | 1 | 1 tells the output stage to go to high impedance |

## Verification
A corrupted tick or step count appears at the duty port as a ramp step that is one or more ticks early or late. It shows up within a single step interval of the fault, which is at most 13 × STEP_UNIT ticks. A wrong phase register shows up within one clock, as an audio_en or out_float value that does not match the current duty. A missed reversal or a bypass decoded the wrong way shows up as a jump in duty of more than one LSB, or as a ramp that runs in the wrong direction. The bench compares all three outputs against a behavioural model on every clock. It drives all four speeds, both bypasses, and reversal, wait-abort and ramp-down-continuation cases, so each of these faults is seen within one clock of its first effect.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_WAIT = 3'd1,
    PH_UP   = 3'd2,
    PH_PLAY = 3'd3,
    PH_DOWN = 3'd4
  } phase_t;

  // Step-interval multiplier for each slope setting: proportions 2:4:6:13
  function automatic int unsigned slope_mult(input logic [1:0] sel);
    case (sel)
      2'b00:   return 2;
      2'b01:   return 4;
      2'b10:   return 6;
      default: return 13;
    endcase
  endfunction

endpackage

// File: rtl/pps_tick_gen.sv
module pps_tick_gen #(
  parameter int unsigned TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/pps_step_timer.sv
module pps_step_timer #(
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [LIM_W-1:0] limit,
  output logic             step
);
  logic [LIM_W-1:0] tcnt;

  // >= keeps stepping sane if the limit shrinks mid-interval
  assign step = tick && !clr && (({1'b0, tcnt} + 1'b1) >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tcnt <= '0;
    else if (clr)  tcnt <= '0;
    else if (tick) tcnt <= step ? '0 : tcnt + 1'b1;
  end
endmodule

// File: rtl/pps_seq_fsm.sv
module pps_seq_fsm
  import pps_pkg::*;
#(
  parameter int unsigned DUTY_W     = 10,
  parameter int unsigned LIM_W      = 8,
  parameter int unsigned WAIT_TICKS = 20,
  parameter int unsigned STEP_UNIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic [1:0]        ramp_speed,
  input  logic              byp_up,
  input  logic              byp_down,
  input  logic              float_en,
  input  logic              step,
  output logic [LIM_W-1:0]  limit,
  output logic              phase_start,
  output logic [DUTY_W-1:0] duty,
  output logic              audio_en,
  output logic              out_float
);
  localparam logic [DUTY_W-1:0] HALF = {1'b1, {(DUTY_W-1){1'b0}}};
  localparam logic [DUTY_W-1:0] ONE  = DUTY_W'(1);

  phase_t phase;

  always_comb begin
    if (phase == PH_WAIT) limit = LIM_W'(WAIT_TICKS);
    else                  limit = LIM_W'(slope_mult(ramp_speed) * STEP_UNIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      duty        <= '0;
      phase_start <= 1'b0;
    end else begin
      phase_start <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (!pwr_down) begin
            phase       <= PH_WAIT;
            phase_start <= 1'b1;
          end
        end
        PH_WAIT: begin
          if (pwr_down) begin
            phase       <= PH_IDLE;
            phase_start <= 1'b1;
          end else if (step) begin
            phase_start <= 1'b1;
            if (byp_up) begin
              duty  <= HALF;
              phase <= PH_PLAY;
            end else begin
              phase <= PH_UP;
            end
          end
        end
        PH_UP: begin
          if (pwr_down) begin
            phase_start <= 1'b1;
            if (byp_down || duty == '0) begin
              duty  <= '0;
              phase <= PH_IDLE;
            end else begin
              phase <= PH_DOWN;
            end
          end else if (step) begin
            duty <= duty + ONE;
            if (duty + ONE == HALF) begin
              phase       <= PH_PLAY;
              phase_start <= 1'b1;
            end
          end
        end
        PH_PLAY: begin
          if (pwr_down) begin
            phase_start <= 1'b1;
            if (byp_down) begin
              duty  <= '0;
              phase <= PH_IDLE;
            end else begin
              phase <= PH_DOWN;
            end
          end
        end
        PH_DOWN: begin
          if (step) begin
            duty <= duty - ONE;
            if (duty == ONE) begin
              phase       <= PH_IDLE;
              phase_start <= 1'b1;
            end
          end
        end
        default: begin
          phase <= PH_IDLE;
          duty  <= '0;
        end
      endcase
    end
  end

  assign audio_en  = (phase == PH_PLAY);
  assign out_float = float_en && (phase == PH_IDLE);
endmodule

// File: rtl/pwm_pop_sequencer.sv
module pwm_pop_sequencer #(
  parameter int unsigned DUTY_W     = 10,
  parameter int unsigned TICK_DIV   = 12000,
  parameter int unsigned STEP_UNIT  = 5,
  parameter int unsigned WAIT_TICKS = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic [1:0]        ramp_speed,
  input  logic              byp_up,
  input  logic              byp_down,
  input  logic              float_en,
  output logic [DUTY_W-1:0] duty,
  output logic              audio_en,
  output logic              out_float
);
  localparam int unsigned MAX_RAMP = 13 * STEP_UNIT;
  localparam int unsigned MAX_LIM  = (MAX_RAMP > WAIT_TICKS) ? MAX_RAMP : WAIT_TICKS;
  localparam int unsigned LIM_W    = $clog2(MAX_LIM + 1);

  logic             tick;
  logic             step;
  logic             phase_start;
  logic [LIM_W-1:0] limit;

  pps_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  pps_step_timer #(.LIM_W(LIM_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (phase_start),
    .tick (tick),
    .limit(limit),
    .step (step)
  );

  pps_seq_fsm #(
    .DUTY_W    (DUTY_W),
    .LIM_W     (LIM_W),
    .WAIT_TICKS(WAIT_TICKS),
    .STEP_UNIT (STEP_UNIT)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_down   (pwr_down),
    .ramp_speed (ramp_speed),
    .byp_up     (byp_up),
    .byp_down   (byp_down),
    .float_en   (float_en),
    .step       (step),
    .limit      (limit),
    .phase_start(phase_start),
    .duty       (duty),
    .audio_en   (audio_en),
    .out_float  (out_float)
  );
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
  parameter int unsigned DUTY_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_down,
  input logic              byp_up,
  input logic              byp_down,
  input logic              float_en,
  input logic [DUTY_W-1:0] duty,
  input logic              audio_en,
  input logic              out_float
);
  localparam logic [DUTY_W-1:0] HALF = {1'b1, {(DUTY_W-1){1'b0}}};
  localparam logic [DUTY_W-1:0] ONE  = DUTY_W'(1);

  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (duty == '0 && !audio_en);
    end
  end

  assert_duty_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    duty <= HALF);

  assert_audio_at_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    audio_en |-> duty == HALF);

  assert_single_lsb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (duty != $past(duty) && !$past(byp_up) && !$past(byp_down))
      |-> (duty == $past(duty) + ONE || $past(duty) == duty + ONE));

  assert_audio_off_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (audio_en && pwr_down && !byp_down) |=> (!audio_en && duty == HALF));

  assert_float_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_float |-> (float_en && duty == '0 && !audio_en));

  assert_audio_needs_powerup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(audio_en) |-> !$past(pwr_down));
endmodule

bind pwm_pop_sequencer pps_checker #(.DUTY_W(DUTY_W)) u_pps_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr_down (pwr_down),
  .byp_up   (byp_up),
  .byp_down (byp_down),
  .float_en (float_en),
  .duty     (duty),
  .audio_en (audio_en),
  .out_float(out_float)
);

// File: tb/test_pwm_pop_sequencer.sv
`timescale 1ns/1ps
module test_pwm_pop_sequencer;
  localparam int DUTY_W = 6;
  localparam int TDIV   = 2;
  localparam int SUNIT  = 1;
  localparam int WTICK  = 5;
  localparam int HALF   = 1 << (DUTY_W - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_down = 1'b1;
  logic [1:0] ramp_speed = 2'b00;
  logic byp_up = 1'b0, byp_down = 1'b0, float_en = 1'b1;
  logic [DUTY_W-1:0] duty;
  logic audio_en, out_float;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pwm_pop_sequencer #(.DUTY_W(DUTY_W), .TICK_DIV(TDIV), .STEP_UNIT(SUNIT), .WAIT_TICKS(WTICK))
    i_pwm_pop_sequencer (
      .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .ramp_speed(ramp_speed),
      .byp_up(byp_up), .byp_down(byp_down), .float_en(float_en),
      .duty(duty), .audio_en(audio_en), .out_float(out_float));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model: 0 idle, 1 wait, 2 up, 3 play, 4 down
  int m_ph = 0, m_duty = 0, m_pc = 0, m_tc = 0;
  bit m_start = 0;

  function automatic int mult(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 4 : (s == 2'd2) ? 6 : 13;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_duty = 0; m_pc = 0; m_tc = 0; m_start = 0;
    end else begin
      bit tk, st, nstart;
      int lim;
      tk = (m_pc == TDIV - 1);
      m_pc = tk ? 0 : m_pc + 1;
      lim = (m_ph == 1) ? WTICK : mult(ramp_speed) * SUNIT;
      st = tk && !m_start && (m_tc + 1 >= lim);
      if (m_start) m_tc = 0;
      else if (tk) m_tc = st ? 0 : m_tc + 1;
      nstart = 0;
      case (m_ph)
        0: if (!pwr_down) begin m_ph = 1; nstart = 1; end
        1: if (pwr_down) begin m_ph = 0; nstart = 1; end
           else if (st) begin
             nstart = 1;
             if (byp_up) begin m_duty = HALF; m_ph = 3; end else m_ph = 2;
           end
        2: if (pwr_down) begin
             nstart = 1;
             if (byp_down || m_duty == 0) begin m_duty = 0; m_ph = 0; end else m_ph = 4;
           end else if (st) begin
             m_duty++;
             if (m_duty == HALF) begin m_ph = 3; nstart = 1; end
           end
        3: if (pwr_down) begin
             nstart = 1;
             if (byp_down) begin m_duty = 0; m_ph = 0; end else m_ph = 4;
           end
        default: if (st) begin
             m_duty--;
             if (m_duty == 0) begin m_ph = 0; nstart = 1; end
           end
      endcase
      m_start = nstart;
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    chk(int'(duty) == m_duty, "R3/R5 duty vs model", int'(duty), m_duty);
    chk(audio_en == (m_ph == 3), "R4 audio_en vs model", int'(audio_en), int'(m_ph == 3));
    chk(out_float == (float_en && m_ph == 0), "R8 out_float vs model",
        int'(out_float), int'(float_en && m_ph == 0));
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_after_neg();
    @(negedge clk); #1;
  endtask

  task automatic wait_duty(input int v);
    while (int'(duty) != v) @(negedge clk);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int prev;
    cyc(3);
    chk(duty == 0 && !audio_en, "R1 reset duty/audio", int'(duty), 0);
    chk(out_float == 1'b1, "R1 reset float follows float_en", int'(out_float), 1);
    drive_after_neg(); rst_n = 1'b1;
    cyc(12);
    chk(duty == 0, "R2 idle while pwr_down", int'(duty), 0);

    // normal power-up at speed 00
    drive_after_neg(); pwr_down = 1'b0;
    cyc(4);
    chk(duty == 0, "R2 wait phase holds zero", int'(duty), 0);
    chk(out_float == 0, "R8 no float once powering up", int'(out_float), 0);
    while (!audio_en) @(negedge clk);
    chk(int'(duty) == HALF, "R4 audio starts at half", int'(duty), HALF);

    // power-down with ramp
    drive_after_neg(); pwr_down = 1'b1;
    @(negedge clk);
    chk(!audio_en && int'(duty) == HALF, "R5 audio off before duty moves", int'(duty), HALF);
    wait_duty(0);
    chk(out_float == 1, "R8 float when idle and powered down", int'(out_float), 1);

    // reversal mid ramp-up at slowest speed, then R10 continuation
    drive_after_neg(); ramp_speed = 2'b11; pwr_down = 1'b0;
    wait_duty(10);
    #1 pwr_down = 1'b1;
    cyc(2);
    #1 pwr_down = 1'b0;
    prev = 10;
    while (duty != 0) begin
      @(negedge clk);
      chk(int'(duty) <= prev && prev - int'(duty) <= 1, "R9 R10 reverse without jump", int'(duty), prev);
      prev = int'(duty);
    end
    #1 byp_up = 1'b1; ramp_speed = 2'b01;

    // bypassed ramp-up
    prev = 0;
    while (!audio_en) begin prev = int'(duty); @(negedge clk); end
    chk(prev == 0 && int'(duty) == HALF, "R6 bypass jump 0 to half", prev, 0);

    // bypassed ramp-down
    drive_after_neg(); byp_down = 1'b1; pwr_down = 1'b1;
    @(negedge clk);
    chk(duty == 0 && !audio_en, "R7 bypass drop to zero", int'(duty), 0);

    // wait abort, float disabled
    drive_after_neg(); float_en = 1'b0; byp_up = 1'b0; byp_down = 1'b0; pwr_down = 1'b0;
    cyc(2);
    #1 pwr_down = 1'b1;
    cyc(40);
    chk(duty == 0 && !audio_en, "R2 wait abort leaves no ramp", int'(duty), 0);
    chk(out_float == 0, "R8 float_en low keeps pins driven", int'(out_float), 0);

    // speed 01 up, speed 10 down, pwr_down before first step
    drive_after_neg(); ramp_speed = 2'b01; pwr_down = 1'b0;
    while (!audio_en) @(negedge clk);
    chk(int'(duty) == HALF, "R3 speed 01 reaches half", int'(duty), HALF);
    drive_after_neg(); ramp_speed = 2'b10; pwr_down = 1'b1;
    wait_duty(0);
    drive_after_neg(); pwr_down = 1'b0;
    while (duty != 0 || audio_en) @(negedge clk);
    cyc(WTICK * TDIV + 1);
    #1 pwr_down = 1'b1;
    cyc(3);
    chk(duty == 0 && !audio_en, "R9 pwr_down at duty zero returns idle", int'(duty), 0);
    cyc(5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule